// File: doc/BRIEF.md
# Multi-Lane Vector Execution Unit

This block executes element-wise integer operations over whole vector registers. One accepted instruction covers every element of a register. A small number of parallel lanes does the work over several cycles. The unit holds a bank of vector registers and one scalar register. It supports four vector operations: loading a register from memory, storing a register to memory, adding two registers, and scaling a register by the scalar. A fifth instruction sets the scalar. Together these are enough to compute `Y = a*X + Y` in six instructions.

The elements of a register are spread over the lanes in an interleaved pattern, and each lane keeps its own slice of every register. On each beat, every lane handles one element. A full register therefore takes the element count divided by the lane count beats. Loads and stores step through consecutive word addresses starting at a base address. On each beat they present one word per lane to a memory port, and that port answers reads one cycle later. Results for different elements never depend on each other, so an instruction may name the same register as source and destination. No hazard logic exists inside an instruction.

Top module: `vxu_top`

## Requirements
- R1: After reset, `busy` and `mem_req` are low and `instr_ready` is high.
- R2: An instruction is taken on a clock edge where `instr_valid` and `instr_ready` are both high. `instr_ready` is low for every cycle in which `busy` is high, and an accepted vector instruction raises `busy` on the next cycle.
- R3: Opcode 0 (set scalar) copies `instr_imm` into the scalar register in one cycle. It leaves `busy` low, and the scalar does not change while a vector instruction runs.
- R4: Opcode 1 (vector load) writes the word at address `instr_base + i` into element i of register `instr_vd`, for every i from 0 to ELEMS-1.
- R5: Opcode 2 (vector store) writes element i of register `instr_vs1` to address `instr_base + i`, for every i.
- R6: Opcode 3 (vector add) sets element i of `instr_vd` to the sum of element i of `instr_vs1` and element i of `instr_vs2`, modulo 2^DATA_W.
- R7: Opcode 4 (vector-scalar multiply) sets element i of `instr_vd` to the scalar times element i of `instr_vs1`, keeping the low DATA_W bits.
- R8: `busy` stays high for ELEMS/LANES cycles after an add, multiply or store is accepted, and for ELEMS/LANES+1 cycles after a load is accepted.
- R9: On each cycle with `mem_req` high, lane k drives address `mem_addr[k*ADDR_W +: ADDR_W]`, equal to lane 0's address plus k. The first beat of an access uses the base address, and each following beat adds LANES to lane 0's address.
- R10: A destination register equal to a source register gives the element-wise result computed from the original source values.
- R11: Opcodes 5 to 7 are accepted and do nothing: `busy` stays low and no register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | Instruction offered |
| instr_ready | output | 1 | Unit can take an instruction |
| instr_op | input | 3 | Opcode (0 set scalar, 1 load, 2 store, 3 add, 4 scale) |
| instr_vd | input | $clog2(NREGS) | Destination vector register |
| instr_vs1 | input | $clog2(NREGS) | First source register (store source) |
| instr_vs2 | input | $clog2(NREGS) | Second source register |
| instr_base | input | ADDR_W | Base word address for load/store |
| instr_imm | input | DATA_W | Immediate for set scalar |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | LANES*ADDR_W | One word address per lane |
| mem_wdata | output | LANES*DATA_W | One write word per lane |
| mem_rdata | input | LANES*DATA_W | Read words, one cycle after the request |
| busy | output | 1 | A vector instruction is in progress |

## Verification
The arithmetic paths are fed three data sets. The first is small increasing values, whose scaled sums reveal a swapped operand or a missing scale. The second is a distinct linear sequence for the second operand, so any lane or beat misplacement shows up as a wrong element. The third is words near the top of the range, whose products wrap, to separate truncation from any other width handling. Each data set is read back through a store to a fresh region. This also detects an element written to the wrong lane slot or beat. An in-place add and an illegal opcode between a load and a store check that reused and untouched registers keep the right contents. A port monitor follows every memory beat's lane addresses.

// File: rtl/vxu_pkg.sv
package vxu_pkg;

  typedef enum logic [2:0] {
    OP_SETS  = 3'd0,
    OP_VLD   = 3'd1,
    OP_VST   = 3'd2,
    OP_VADD  = 3'd3,
    OP_VSMUL = 3'd4
  } vop_e;

  function automatic logic op_is_vector(input logic [2:0] op);
    return (op == OP_VLD) || (op == OP_VST) || (op == OP_VADD) || (op == OP_VSMUL);
  endfunction

  function automatic logic op_is_arith(input logic [2:0] op);
    return (op == OP_VADD) || (op == OP_VSMUL);
  endfunction

endpackage

// File: rtl/vxu_seq.sv
module vxu_seq
  import vxu_pkg::*;
#(
  parameter int BEATS  = 16,
  parameter int LANES  = 4,
  parameter int ADDR_W = 16,
  parameter int RIDX_W = 3,
  localparam int BEAT_W = (BEATS > 1) ? $clog2(BEATS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [2:0]        start_op,
  input  logic [RIDX_W-1:0] start_vd,
  input  logic [RIDX_W-1:0] start_vs1,
  input  logic [RIDX_W-1:0] start_vs2,
  input  logic [ADDR_W-1:0] start_base,
  output logic              busy,
  output logic [BEAT_W-1:0] rd_beat,
  output logic [RIDX_W-1:0] rd_vs1,
  output logic [RIDX_W-1:0] rd_vs2,
  output logic              wr_en,
  output logic [BEAT_W-1:0] wr_beat,
  output logic [RIDX_W-1:0] wr_vd,
  output logic              wr_from_mem,
  output logic              use_mul,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] beat_addr
);

  logic              active;
  logic [BEAT_W-1:0] cnt;
  logic [2:0]        op_q;
  logic [RIDX_W-1:0] vd_q, vs1_q, vs2_q;
  logic [ADDR_W-1:0] base_q;
  logic              pend;
  logic [BEAT_W-1:0] pend_beat;
  logic [RIDX_W-1:0] pend_vd;

  // named internal events for the checks
  logic at_last, is_ld, is_st, last_evt;
  assign at_last  = active && (cnt == BEAT_W'(BEATS - 1));
  assign is_ld    = (op_q == OP_VLD);
  assign is_st    = (op_q == OP_VST);
  assign last_evt = (at_last && !is_ld) || (pend && (pend_beat == BEAT_W'(BEATS - 1)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active    <= 1'b0;
      cnt       <= '0;
      op_q      <= OP_SETS;
      vd_q      <= '0;
      vs1_q     <= '0;
      vs2_q     <= '0;
      base_q    <= '0;
      pend      <= 1'b0;
      pend_beat <= '0;
      pend_vd   <= '0;
    end else begin
      if (start) begin
        active <= 1'b1;
        cnt    <= '0;
        op_q   <= start_op;
        vd_q   <= start_vd;
        vs1_q  <= start_vs1;
        vs2_q  <= start_vs2;
        base_q <= start_base;
      end else if (active) begin
        if (at_last) active <= 1'b0;
        else         cnt    <= cnt + 1'b1;
      end
      pend      <= active && is_ld;
      pend_beat <= cnt;
      pend_vd   <= vd_q;
    end
  end

  assign busy        = active || pend;
  assign rd_beat     = cnt;
  assign rd_vs1      = vs1_q;
  assign rd_vs2      = vs2_q;
  assign wr_en       = (active && op_is_arith(op_q)) || pend;
  assign wr_beat     = pend ? pend_beat : cnt;
  assign wr_vd       = pend ? pend_vd : vd_q;
  assign wr_from_mem = pend;
  assign use_mul     = (op_q == OP_VSMUL);
  assign mem_req     = active && (is_ld || is_st);
  assign mem_we      = active && is_st;
  assign beat_addr   = base_q + (ADDR_W'(cnt) * ADDR_W'(LANES));

  // R8
  beat_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !at_last) |=> (active && cnt == BEAT_W'($past(cnt) + 1'b1)));

  // R8
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(last_evt));

  // R4
  load_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend |-> $past(mem_req && !mem_we));

endmodule

// File: rtl/vxu_lane.sv
module vxu_lane #(
  parameter int NREGS  = 8,
  parameter int DEPTH  = 16,
  parameter int DATA_W = 32,
  localparam int RIDX_W = $clog2(NREGS),
  localparam int BEAT_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic [BEAT_W-1:0] rd_beat,
  input  logic [RIDX_W-1:0] rd_vs1,
  input  logic [RIDX_W-1:0] rd_vs2,
  input  logic              wr_en,
  input  logic [BEAT_W-1:0] wr_beat,
  input  logic [RIDX_W-1:0] wr_vd,
  input  logic              wr_from_mem,
  input  logic              use_mul,
  input  logic [DATA_W-1:0] scalar,
  input  logic [DATA_W-1:0] mem_word,
  output logic [DATA_W-1:0] st_word
);

  function automatic logic [DATA_W-1:0] elem_add(input logic [DATA_W-1:0] a,
                                                 input logic [DATA_W-1:0] b);
    return a + b;
  endfunction

  function automatic logic [DATA_W-1:0] elem_scale(input logic [DATA_W-1:0] s,
                                                   input logic [DATA_W-1:0] a);
    return s * a;
  endfunction

  // slice of every register held by this lane: element lane + LANES*beat
  logic [DATA_W-1:0] rf [NREGS][DEPTH];

  logic [DATA_W-1:0] opa, opb, alu_res, wr_val;
  assign opa     = rf[rd_vs1][rd_beat];
  assign opb     = rf[rd_vs2][rd_beat];
  assign alu_res = use_mul ? elem_scale(scalar, opa) : elem_add(opa, opb);
  assign wr_val  = wr_from_mem ? mem_word : alu_res;
  assign st_word = opa;

  always_ff @(posedge clk) begin
    if (wr_en) rf[wr_vd][wr_beat] <= wr_val;
  end

endmodule

// File: rtl/vxu_top.sv
module vxu_top
  import vxu_pkg::*;
#(
  parameter int ELEMS  = 64,
  parameter int LANES  = 4,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 16,
  parameter int NREGS  = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       instr_valid,
  output logic                       instr_ready,
  input  logic [2:0]                 instr_op,
  input  logic [$clog2(NREGS)-1:0]   instr_vd,
  input  logic [$clog2(NREGS)-1:0]   instr_vs1,
  input  logic [$clog2(NREGS)-1:0]   instr_vs2,
  input  logic [ADDR_W-1:0]          instr_base,
  input  logic [DATA_W-1:0]          instr_imm,
  output logic                       mem_req,
  output logic                       mem_we,
  output logic [LANES*ADDR_W-1:0]    mem_addr,
  output logic [LANES*DATA_W-1:0]    mem_wdata,
  input  logic [LANES*DATA_W-1:0]    mem_rdata,
  output logic                       busy
);

  localparam int BEATS  = ELEMS / LANES;
  localparam int RIDX_W = $clog2(NREGS);
  localparam int BEAT_W = (BEATS > 1) ? $clog2(BEATS) : 1;

  logic accept, start, set_scalar;
  logic [DATA_W-1:0] scalar_q;

  assign instr_ready = !busy;
  assign accept      = instr_valid && instr_ready;
  assign start       = accept && op_is_vector(instr_op);
  assign set_scalar  = accept && (instr_op == OP_SETS);

  always_ff @(posedge clk) begin
    if (!rst_n)          scalar_q <= '0;
    else if (set_scalar) scalar_q <= instr_imm;
  end

  logic [BEAT_W-1:0] rd_beat, wr_beat;
  logic [RIDX_W-1:0] rd_vs1, rd_vs2, wr_vd;
  logic              wr_en, wr_from_mem, use_mul;
  logic [ADDR_W-1:0] beat_addr;

  vxu_seq #(
    .BEATS (BEATS),
    .LANES (LANES),
    .ADDR_W(ADDR_W),
    .RIDX_W(RIDX_W)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .start_op   (instr_op),
    .start_vd   (instr_vd),
    .start_vs1  (instr_vs1),
    .start_vs2  (instr_vs2),
    .start_base (instr_base),
    .busy       (busy),
    .rd_beat    (rd_beat),
    .rd_vs1     (rd_vs1),
    .rd_vs2     (rd_vs2),
    .wr_en      (wr_en),
    .wr_beat    (wr_beat),
    .wr_vd      (wr_vd),
    .wr_from_mem(wr_from_mem),
    .use_mul    (use_mul),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .beat_addr  (beat_addr)
  );

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign mem_addr[k*ADDR_W +: ADDR_W] = beat_addr + ADDR_W'(k);

    vxu_lane #(
      .NREGS (NREGS),
      .DEPTH (BEATS),
      .DATA_W(DATA_W)
    ) u_lane (
      .clk        (clk),
      .rd_beat    (rd_beat),
      .rd_vs1     (rd_vs1),
      .rd_vs2     (rd_vs2),
      .wr_en      (wr_en),
      .wr_beat    (wr_beat),
      .wr_vd      (wr_vd),
      .wr_from_mem(wr_from_mem),
      .use_mul    (use_mul),
      .scalar     (scalar_q),
      .mem_word   (mem_rdata[k*DATA_W +: DATA_W]),
      .st_word    (mem_wdata[k*DATA_W +: DATA_W])
    );
  end

  // R2
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid && instr_ready && op_is_vector(instr_op)) |=> busy);

  // R3
  scalar_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(scalar_q));

  // R9
  lane_stride_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && $past(mem_req)) |->
      (mem_addr[ADDR_W-1:0] == $past(mem_addr[ADDR_W-1:0]) + ADDR_W'(LANES)));

  // R11
  illegal_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid && instr_ready && (instr_op > 3'd4)) |=> !busy);

endmodule

// File: tb/vxu_top_test.sv
module vxu_top_test;

  localparam int ELEMS = 64;
  localparam int LANES = 4;
  localparam int BEATS = ELEMS / LANES;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        instr_valid = 1'b0;
  logic        instr_ready;
  logic [2:0]  instr_op = '0;
  logic [2:0]  instr_vd = '0, instr_vs1 = '0, instr_vs2 = '0;
  logic [15:0] instr_base = '0;
  logic [31:0] instr_imm = '0;
  logic        mem_req, mem_we, busy;
  logic [LANES*16-1:0] mem_addr;
  logic [LANES*32-1:0] mem_wdata;
  logic [LANES*32-1:0] mem_rdata;

  int checks = 0;
  int bad = 0;
  logic [15:0] exp_base = '0;

  always #5 clk = ~clk;

  vxu_top uut (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_ready(instr_ready),
    .instr_op(instr_op), .instr_vd(instr_vd), .instr_vs1(instr_vs1), .instr_vs2(instr_vs2),
    .instr_base(instr_base), .instr_imm(instr_imm), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .busy(busy)
  );

  // word memory, one-cycle read latency
  logic [31:0] mem [0:1023];
  logic [31:0] rdata_q [LANES];
  for (genvar k = 0; k < LANES; k++) begin : g_rd
    assign mem_rdata[k*32 +: 32] = rdata_q[k];
  end

  always @(posedge clk) begin
    if (mem_req) begin
      for (int k = 0; k < LANES; k++) begin
        if (mem_we) mem[mem_addr[k*16 +: 10]] <= mem_wdata[k*32 +: 32];
        else        rdata_q[k] <= mem[mem_addr[k*16 +: 10]];
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // R9 monitor of per-lane addresses on every memory beat
  logic prev_req = 1'b0;
  logic [15:0] prev_a0 = '0;
  always @(negedge clk) begin
    if (rst_n && mem_req) begin
      for (int k = 1; k < LANES; k++)
        chk("R9 lane offset", 32'(mem_addr[k*16 +: 16]), 32'(mem_addr[15:0] + 16'(k)));
      if (prev_req) chk("R9 beat stride", 32'(mem_addr[15:0]), 32'(prev_a0 + 16'(LANES)));
      else          chk("R9 first beat", 32'(mem_addr[15:0]), 32'(exp_base));
    end
    prev_req = rst_n && mem_req;
    prev_a0  = mem_addr[15:0];
  end

  function automatic logic [31:0] xval(input int i);   return 32'(i * 3 + 1);        endfunction
  function automatic logic [31:0] yval(input int i);   return 32'(1000 + i * 7);     endfunction
  function automatic logic [31:0] bigval(input int i); return 32'hFFFF_FFF0 + 32'(i); endfunction

  task automatic issue(input logic [2:0] op, input logic [2:0] vd, input logic [2:0] vs1,
                       input logic [2:0] vs2, input logic [15:0] base, input logic [31:0] imm,
                       input int exp_busy);
    int n;
    @(negedge clk);
    while (!instr_ready) @(negedge clk);
    instr_op = op; instr_vd = vd; instr_vs1 = vs1; instr_vs2 = vs2;
    instr_base = base; instr_imm = imm; instr_valid = 1'b1;
    exp_base = base;
    @(negedge clk);
    instr_valid = 1'b0;
    n = 0;
    while (busy && n < 100) begin
      chk("R2 ready low while busy", 32'(instr_ready), 32'd0);
      n++;
      @(negedge clk);
    end
    chk("R8 busy cycles", 32'(n), 32'(exp_busy));
  endtask

  task automatic check_region(input logic [15:0] base, input int kind, input string req);
    logic [31:0] e;
    for (int i = 0; i < ELEMS; i++) begin
      case (kind)
        0: e = xval(i);
        1: e = 32'd5 * xval(i) + yval(i);
        2: e = yval(i) + yval(i);
        default: e = 32'd3 * bigval(i);
      endcase
      chk(req, mem[base + 16'(i)], e);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 busy", 32'(busy), 32'd0);
    chk("R1 ready", 32'(instr_ready), 32'd1);
    chk("R1 mem_req", 32'(mem_req), 32'd0);
    rst_n = 1'b1;
  endtask

  task automatic t_axpy();
    issue(3'd0, 3'd0, 3'd0, 3'd0, 16'd0, 32'd5, 0);      // R3 set scalar, no busy
    issue(3'd1, 3'd1, 3'd0, 3'd0, 16'd0, 32'd0, BEATS + 1);  // R4 load X
    issue(3'd1, 3'd3, 3'd0, 3'd0, 16'd64, 32'd0, BEATS + 1); // R4 load Y
    issue(3'd4, 3'd2, 3'd1, 3'd0, 16'd0, 32'd0, BEATS);      // R7 scale
    issue(3'd3, 3'd4, 3'd2, 3'd3, 16'd0, 32'd0, BEATS);      // R6 add
    issue(3'd2, 3'd0, 3'd4, 3'd0, 16'd256, 32'd0, BEATS);    // R5 store
    check_region(16'd256, 1, "R6 R7 R5 a*X+Y");
    issue(3'd2, 3'd0, 3'd1, 3'd0, 16'd320, 32'd0, BEATS);
    check_region(16'd320, 0, "R4 load roundtrip");
  endtask

  task automatic t_inplace();
    issue(3'd3, 3'd3, 3'd3, 3'd3, 16'd0, 32'd0, BEATS);      // R10
    issue(3'd2, 3'd0, 3'd3, 3'd0, 16'd384, 32'd0, BEATS);
    check_region(16'd384, 2, "R10 in-place add");
  endtask

  task automatic t_wrap();
    issue(3'd0, 3'd0, 3'd0, 3'd0, 16'd0, 32'd3, 0);
    issue(3'd1, 3'd5, 3'd0, 3'd0, 16'd128, 32'd0, BEATS + 1);
    issue(3'd4, 3'd5, 3'd5, 3'd0, 16'd0, 32'd0, BEATS);
    issue(3'd2, 3'd0, 3'd5, 3'd0, 16'd448, 32'd0, BEATS);
    check_region(16'd448, 3, "R7 wrapped product");
  endtask

  task automatic t_illegal();
    issue(3'd7, 3'd1, 3'd3, 3'd3, 16'd0, 32'd0, 0);          // R11
    issue(3'd2, 3'd0, 3'd1, 3'd0, 16'd512, 32'd0, BEATS);
    check_region(16'd512, 0, "R11 illegal op leaves v1");
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = '0;
    for (int i = 0; i < ELEMS; i++) begin
      mem[i]       = xval(i);
      mem[64 + i]  = yval(i);
      mem[128 + i] = bigval(i);
    end
    for (int k = 0; k < LANES; k++) rdata_q[k] = '0;
    t_reset();
    t_axpy();
    t_inplace();
    t_wrap();
    t_illegal();
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

endmodule